// File: doc/BRIEF.md
# Synchronized-Reload PWM Generator

This block is one PWM generator channel. A power-of-two prescaler slows the system clock into counter ticks. On each tick a down-counter steps from its period value toward zero and then reloads. Three counter events drive the output through a programmable action word: the reload (load) event, the compare match while counting down, and the zero event. With the action word 0x8c, the output goes high at each reload and low at the compare match. Setting the compare value to about half the period then gives a near-square wave.

Software programs the period and compare values through a small write port. Those writes land in shadow copies and do not disturb the running waveform. A separate update request in the control word arms a transfer. At the next tick where the counter sits at zero, both shadow values move into the active copies together. The counter then reloads straight from the new period. As a result, a period change can never stretch a pulse past the correct high time of either the old or the new setting. While the channel is disabled, the output is held low and the active copies track the shadows. Enabling the channel starts counting with a fresh load event.

Top module: `pwm_sync_gen`

## Requirements
- R1: After reset, pwm_out is 0, upd_pending is 0 and count_out is 0.
- R2: The control field wr_data[4:2] (address 3) selects a prescale divide of 2^sel system clocks per counter tick, so sel=6 gives one tick every 64 clocks. Between ticks, count_out holds its value.
- R3: On each tick, count_out decrements by one. From 0 it reloads to the active period value P, so one period lasts P+1 ticks.
- R4: Writes to the period register (address 0) and the compare register (address 1) do not change the running waveform until an update is requested.
- R5: Writing address 3 with bit 1 set raises upd_pending on the next cycle. At the next tick with count_out at 0, both shadow values become active, the counter reloads from the new period and upd_pending drops.
- R6: The action word (address 2) has 2-bit fields: zero event in bits 1:0, load event in bits 3:2, compare-down event in bits 7:6. Bits 5:4 are ignored. The codes are 00 hold, 01 toggle, 10 drive low, 11 drive high. When events coincide, load beats compare and compare beats zero.
- R7: If the active compare value is greater than or equal to the active period, no compare event occurs. With action 0x8c the output then stays high.
- R8: Control bit 0 enables the channel. While it is disabled, pwm_out is 0 and count_out equals the period shadow. After enabling, the first tick is a load event.
- R9: With action 0x8c, every high pulse across any sequence of synchronized period changes lasts exactly P-C ticks for the (P, C) pair of either the old or the new setting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | 0 period, 1 compare, 2 action word, 3 control |
| wr_data | input | 16 | Write data |
| pwm_out | output | 1 | PWM waveform |
| upd_pending | output | 1 | Update requested but not yet transferred |
| count_out | output | 16 | Current down-counter value |

## Verification
The reference model follows the waveform clock by clock. It is driven with two periods that alternate (P=9/C=4 and P=19/C=9). Each update request lands at a different phase within the period, so a transfer taken at the wrong moment would show up as a high pulse of a third length. Unsynchronized shadow writes show that the running period is untouched. A compare value above the period separates "compare suppressed" from "compare fires late". A zero period, where load and zero events coincide every tick, exposes the event priority. A divide-by-64 run with gaps measured between counter steps catches a wrong prescaler limit. Disabling and re-enabling checks the forced-low output and the fresh first pulse.

// File: rtl/pwm_pkg.sv
package pwm_pkg;

  typedef enum logic [1:0] {
    ACT_HOLD   = 2'b00,
    ACT_TOGGLE = 2'b01,
    ACT_LOW    = 2'b10,
    ACT_HIGH   = 2'b11
  } act_e;

  typedef struct packed {
    act_e on_cmpd;
    act_e on_load;
    act_e on_zero;
  } gen_cfg_t;

  localparam logic [1:0] ADDR_PERIOD = 2'd0;
  localparam logic [1:0] ADDR_CMP    = 2'd1;
  localparam logic [1:0] ADDR_ACTION = 2'd2;
  localparam logic [1:0] ADDR_CTRL   = 2'd3;

  localparam int CTRL_EN_BIT  = 0;
  localparam int CTRL_REQ_BIT = 1;
  localparam int CTRL_SEL_LSB = 2;

  function automatic logic apply_act(input act_e a, input logic cur);
    case (a)
      ACT_TOGGLE: apply_act = ~cur;
      ACT_LOW:    apply_act = 1'b0;
      ACT_HIGH:   apply_act = 1'b1;
      default:    apply_act = cur;
    endcase
  endfunction

  function automatic gen_cfg_t unpack_action(input logic [7:0] d);
    gen_cfg_t g;
    g.on_cmpd = act_e'(d[7:6]);
    g.on_load = act_e'(d[3:2]);
    g.on_zero = act_e'(d[1:0]);
    return g;
  endfunction

endpackage

// File: rtl/pwm_prescaler.sv
module pwm_prescaler #(
  parameter int SEL_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [SEL_W-1:0] div_sel,
  output logic             tick
);
  localparam int PRE_W = (1 << SEL_W) - 1;

  logic [PRE_W-1:0] pcnt;
  logic [PRE_W:0]   one_hot;
  logic [PRE_W-1:0] limit;

  always_comb begin
    one_hot = (PRE_W+1)'(1) << div_sel;
    limit   = PRE_W'(one_hot - 1'b1);
  end

  assign tick = run && (pcnt == limit);

  always_ff @(posedge clk) begin
    if (!rst_n)     pcnt <= '0;
    else if (!run)  pcnt <= '0;
    else if (tick)  pcnt <= '0;
    else            pcnt <= pcnt + 1'b1;
  end
endmodule

// File: rtl/pwm_regs.sv
module pwm_regs
  import pwm_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int SEL_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       wr_addr,
  input  logic [CNT_W-1:0] wr_data,
  input  logic             xfer,
  output logic             run,
  output logic [SEL_W-1:0] div_sel,
  output logic [CNT_W-1:0] period_sh,
  output logic [CNT_W-1:0] period_act,
  output logic [CNT_W-1:0] cmp_act,
  output gen_cfg_t         gen_cfg,
  output logic             pending,
  output logic             set_req
);
  logic [CNT_W-1:0] cmp_sh;
  logic             wr_period, wr_cmp, wr_action, wr_ctrl;

  assign wr_period = wr_en && (wr_addr == ADDR_PERIOD);
  assign wr_cmp    = wr_en && (wr_addr == ADDR_CMP);
  assign wr_action = wr_en && (wr_addr == ADDR_ACTION);
  assign wr_ctrl   = wr_en && (wr_addr == ADDR_CTRL);
  assign set_req   = wr_ctrl && wr_data[CTRL_REQ_BIT];

  // shadow side: written directly by the port
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      period_sh <= '0;
      cmp_sh    <= '0;
      gen_cfg   <= '0;
      run       <= 1'b0;
      div_sel   <= '0;
    end else begin
      if (wr_period) period_sh <= wr_data;
      if (wr_cmp)    cmp_sh    <= wr_data;
      if (wr_action) gen_cfg   <= unpack_action(wr_data[7:0]);
      if (wr_ctrl) begin
        run     <= wr_data[CTRL_EN_BIT];
        div_sel <= wr_data[CTRL_SEL_LSB +: SEL_W];
      end
    end
  end

  // active side: follows shadows while idle, otherwise only on transfer
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      period_act <= '0;
      cmp_act    <= '0;
    end else if (!run || xfer) begin
      period_act <= period_sh;
      cmp_act    <= cmp_sh;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) pending <= 1'b0;
    else        pending <= set_req || (pending && run && !xfer);
  end
endmodule

// File: rtl/pwm_counter.sv
module pwm_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             tick,
  input  logic             pending,
  input  logic [CNT_W-1:0] period_sh,
  input  logic [CNT_W-1:0] period_act,
  input  logic [CNT_W-1:0] cmp_act,
  output logic [CNT_W-1:0] count,
  output logic             ev_zero,
  output logic             ev_load,
  output logic             ev_cmpd,
  output logic             xfer
);
  logic at_zero;

  assign at_zero = (count == '0);
  assign ev_zero = tick && at_zero;
  assign ev_load = tick && (count == period_act);
  assign ev_cmpd = tick && (cmp_act < period_act) && (count == cmp_act);
  assign xfer    = ev_zero && pending;

  always_ff @(posedge clk) begin
    if (!rst_n)       count <= '0;
    else if (!run)    count <= period_sh;
    else if (tick) begin
      if (!at_zero)   count <= count - 1'b1;
      else if (xfer)  count <= period_sh;
      else            count <= period_act;
    end
  end
endmodule

// File: rtl/pwm_output.sv
module pwm_output
  import pwm_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     run,
  input  logic     ev_zero,
  input  logic     ev_load,
  input  logic     ev_cmpd,
  input  gen_cfg_t gen_cfg,
  output logic     pwm_q
);
  logic nxt;

  always_comb begin
    if (ev_load)      nxt = apply_act(gen_cfg.on_load, pwm_q);
    else if (ev_cmpd) nxt = apply_act(gen_cfg.on_cmpd, pwm_q);
    else if (ev_zero) nxt = apply_act(gen_cfg.on_zero, pwm_q);
    else              nxt = pwm_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)    pwm_q <= 1'b0;
    else if (!run) pwm_q <= 1'b0;
    else           pwm_q <= nxt;
  end
endmodule

// File: rtl/pwm_sync_gen.sv
module pwm_sync_gen
  import pwm_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int SEL_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       wr_addr,
  input  logic [CNT_W-1:0] wr_data,
  output logic             pwm_out,
  output logic             upd_pending,
  output logic [CNT_W-1:0] count_out
);
  logic             run, tick, xfer, set_req;
  logic             ev_zero, ev_load, ev_cmpd;
  logic [SEL_W-1:0] div_sel;
  logic [CNT_W-1:0] period_sh, period_act, cmp_act;
  gen_cfg_t         gen_cfg;

  pwm_regs #(.CNT_W(CNT_W), .SEL_W(SEL_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .xfer(xfer), .run(run), .div_sel(div_sel),
    .period_sh(period_sh), .period_act(period_act), .cmp_act(cmp_act),
    .gen_cfg(gen_cfg), .pending(upd_pending), .set_req(set_req)
  );

  pwm_prescaler #(.SEL_W(SEL_W)) u_pre (
    .clk(clk), .rst_n(rst_n), .run(run), .div_sel(div_sel), .tick(tick)
  );

  pwm_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .run(run), .tick(tick), .pending(upd_pending),
    .period_sh(period_sh), .period_act(period_act), .cmp_act(cmp_act),
    .count(count_out), .ev_zero(ev_zero), .ev_load(ev_load),
    .ev_cmpd(ev_cmpd), .xfer(xfer)
  );

  pwm_output u_out (
    .clk(clk), .rst_n(rst_n), .run(run), .ev_zero(ev_zero),
    .ev_load(ev_load), .ev_cmpd(ev_cmpd), .gen_cfg(gen_cfg), .pwm_q(pwm_out)
  );
endmodule

// File: rtl/pwm_sync_gen_checker.sv
module pwm_sync_gen_checker #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             run,
  input logic             tick,
  input logic             xfer,
  input logic             set_req,
  input logic             ev_cmpd,
  input logic             pwm_out,
  input logic             upd_pending,
  input logic [CNT_W-1:0] count_out,
  input logic [CNT_W-1:0] period_act,
  input logic [CNT_W-1:0] cmp_act
);
  a_r2_hold_between_ticks: assert property (@(posedge clk) disable iff (!rst_n)
    run && !tick |=> $stable(count_out));

  a_r3_step_down: assert property (@(posedge clk) disable iff (!rst_n)
    tick && count_out != '0 |=> count_out == CNT_W'($past(count_out) - 1'b1));

  a_r3_reload_same_period: assert property (@(posedge clk) disable iff (!rst_n)
    tick && count_out == '0 && !xfer |=> count_out == period_act);

  a_r4_active_held: assert property (@(posedge clk) disable iff (!rst_n)
    run && !xfer |=> $stable(period_act) && $stable(cmp_act));

  a_r5_pending_raised: assert property (@(posedge clk) disable iff (!rst_n)
    set_req |=> upd_pending);

  a_r5_pending_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    xfer && !set_req |=> !upd_pending);

  a_r7_cmp_needs_room: assert property (@(posedge clk) disable iff (!rst_n)
    ev_cmpd |-> cmp_act < period_act);

  a_r8_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> !pwm_out);
endmodule

bind pwm_sync_gen pwm_sync_gen_checker #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .run(run), .tick(tick), .xfer(xfer),
  .set_req(set_req), .ev_cmpd(ev_cmpd), .pwm_out(pwm_out),
  .upd_pending(upd_pending), .count_out(count_out),
  .period_act(period_act), .cmp_act(cmp_act)
);

// File: tb/pwm_sync_gen_bench.sv
module pwm_sync_gen_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = 2'd0;
  logic [15:0] wr_data = 16'd0;
  logic        pwm_out, upd_pending;
  logic [15:0] count_out;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  pwm_sync_gen u_pwm_sync_gen (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .pwm_out(pwm_out), .upd_pending(upd_pending),
    .count_out(count_out)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int m_psh, m_csh, m_p, m_c, m_en, m_sel, m_req, m_pre, m_cnt, m_out;
  int m_az, m_al, m_ac;

  function automatic int act_apply(input int code, input int cur);
    if (code == 1) return 1 - cur;
    if (code == 2) return 0;
    if (code == 3) return 1;
    return cur;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_psh = 0; m_csh = 0; m_p = 0; m_c = 0; m_en = 0; m_sel = 0;
      m_req = 0; m_pre = 0; m_cnt = 0; m_out = 0; m_az = 0; m_al = 0; m_ac = 0;
    end else begin
      int tk, xf, n_out, n_cnt, n_p, n_c, n_req, n_pre, setr;
      tk = (m_en != 0) && (m_pre == (1 << m_sel) - 1);
      xf = tk && m_cnt == 0 && m_req != 0;
      setr = wr_en && wr_addr == 3 && wr_data[1];
      n_out = m_out;
      if (m_en == 0) n_out = 0;
      else if (tk && m_cnt == m_p) n_out = act_apply(m_al, m_out);
      else if (tk && m_c < m_p && m_cnt == m_c) n_out = act_apply(m_ac, m_out);
      else if (tk && m_cnt == 0) n_out = act_apply(m_az, m_out);
      n_cnt = m_cnt;
      if (m_en == 0) n_cnt = m_psh;
      else if (tk) n_cnt = (m_cnt != 0) ? m_cnt - 1 : (xf ? m_psh : m_p);
      n_p = m_p; n_c = m_c;
      if (m_en == 0 || xf) begin n_p = m_psh; n_c = m_csh; end
      n_req = setr || (m_req != 0 && m_en != 0 && !xf);
      n_pre = (m_en == 0 || tk) ? 0 : (m_pre + 1) % 128;
      if (wr_en) begin
        case (wr_addr)
          2'd0: m_psh = wr_data;
          2'd1: m_csh = wr_data;
          2'd2: begin m_az = wr_data[1:0]; m_al = wr_data[3:2]; m_ac = wr_data[7:6]; end
          default: begin m_en = wr_data[0]; m_sel = wr_data[4:2]; end
        endcase
      end
      m_out = n_out; m_cnt = n_cnt; m_p = n_p; m_c = n_c; m_req = n_req; m_pre = n_pre;
    end
  end

  // per-clock comparison, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      check(pwm_out == m_out, "R6 pwm_out vs model", pwm_out, m_out);
      check(count_out == m_cnt, "R3 count_out vs model", count_out, m_cnt);
      check(upd_pending == m_req, "R5 upd_pending vs model", upd_pending, m_req);
    end
  end

  // R9 pulse-width monitor
  bit mon_on = 1'b0;
  bit armed = 1'b0;
  int run_len = 0, hA = 0, hB = 0, pulses = 0;
  always @(negedge clk) begin
    if (!mon_on) begin armed = 0; run_len = 0; end
    else if (!armed) begin if (!pwm_out) armed = 1; end
    else if (pwm_out) run_len++;
    else if (run_len > 0) begin
      pulses++;
      check(run_len == hA || run_len == hB, "R9 high pulse length", run_len, hA);
      run_len = 0;
    end
  end

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_clear();
    for (int i = 0; i < 400 && upd_pending; i++) @(negedge clk);
  endtask

  task automatic meas_high(output int n);
    n = 0;
    for (int i = 0; i < 400 && !pwm_out; i++) @(negedge clk);
    for (int i = 0; i < 400 && pwm_out; i++) begin n++; @(negedge clk); end
  endtask

  initial begin
    int n, prev;
    bit stay;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(pwm_out == 0, "R1 pwm_out after reset", pwm_out, 0);
    check(upd_pending == 0, "R1 upd_pending after reset", upd_pending, 0);
    check(count_out == 0, "R1 count_out after reset", count_out, 0);

    wr(0, 16'd9); wr(1, 16'd4); wr(2, 16'h008c);
    check(pwm_out == 0, "R8 disabled output low", pwm_out, 0);
    check(count_out == 9, "R8 idle count follows period shadow", count_out, 9);
    wr(3, 16'h0001);
    @(negedge clk);
    check(pwm_out == 1, "R8 first tick is a load event", pwm_out, 1);
    meas_high(n);
    check(n == 5, "R3 high time P-C", n, 5);
    n = 0;
    for (int i = 0; i < 400 && !pwm_out; i++) begin n++; @(negedge clk); end
    check(n == 5, "R3 low time gives period P+1", n, 5);

    wr(0, 16'd19); wr(1, 16'd9);
    repeat (25) @(negedge clk);
    meas_high(n);
    check(n == 5, "R4 unsynchronized write ignored", n, 5);
    check(upd_pending == 0, "R4 no pending without request", upd_pending, 0);

    wr(3, 16'h0003);
    check(upd_pending == 1, "R5 pending after request", upd_pending, 1);
    wait_clear();
    check(upd_pending == 0, "R5 pending cleared by transfer", upd_pending, 0);
    meas_high(n);
    check(n == 10, "R5 new high time after transfer", n, 10);

    hA = 5; hB = 10; mon_on = 1'b1;
    for (int i = 0; i < 20; i++) begin
      repeat ((i * 7) % 23 + 1) @(negedge clk);
      if (i % 2 == 0) begin wr(0, 16'd9); wr(1, 16'd4); end
      else begin wr(0, 16'd19); wr(1, 16'd9); end
      wr(3, 16'h0003);
      wait_clear();
    end
    repeat (30) @(negedge clk);
    mon_on = 1'b0;
    check(pulses >= 20, "R9 pulses observed across changes", pulses, 20);

    wr(0, 16'd9); wr(1, 16'd12); wr(3, 16'h0003);
    wait_clear();
    repeat (15) @(negedge clk);
    stay = 1'b1;
    for (int i = 0; i < 25; i++) begin stay &= pwm_out; @(negedge clk); end
    check(stay, "R7 compare above period suppressed", stay, 1);

    wr(1, 16'd4); wr(3, 16'h0003);
    wait_clear();
    wr(2, 16'h0001);
    repeat (12) @(negedge clk);
    meas_high(n);
    check(n == 10, "R6 toggle on zero gives one-period high", n, 10);

    wr(2, 16'h000c); wr(0, 16'd0); wr(3, 16'h0003);
    wait_clear();
    repeat (3) @(negedge clk);
    check(pwm_out == 1, "R6 load action drives high", pwm_out, 1);
    wr(2, 16'h000b);
    repeat (2) @(negedge clk);
    check(pwm_out == 0, "R6 load beats zero", pwm_out, 0);

    wr(3, 16'h0000); wr(0, 16'd3);
    @(negedge clk);
    check(pwm_out == 0, "R8 output low when disabled", pwm_out, 0);
    check(count_out == 3, "R8 idle count equals shadow", count_out, 3);
    wr(3, 16'h0019);
    prev = count_out;
    for (int i = 0; i < 200 && count_out == prev; i++) @(negedge clk);
    prev = count_out;
    n = 0;
    for (int i = 0; i < 200 && count_out == prev; i++) begin n++; @(negedge clk); end
    check(n == 64, "R2 divide-by-64 tick spacing", n, 64);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_checks++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule